// File: doc/BRIEF.md
# Burst-Mode Coarse Frequency Acquisition Loop

This block is the coarse digital loop of an all-digital PLL that runs in short bursts to save power. A phase sequencer opens a measurement window one reference period in every ten. While the window is open, the oscillator and its tuning DAC are enabled, and an edge counter clocked by the oscillator output counts its rising edges. One reference period after the window closes, the loop compares that count with a programmed frequency word. The word is the target output frequency over the reference frequency; for a 20 MHz reference and an output between 300 MHz and 1.2 GHz it lies between 15 and 60. The loop then adds the signed error into a saturating 7-bit tuning code.

The new code steers the oscillator in the next burst. Between bursts, both enables are dropped and the code is held. A flag reports when the coarse error is zero, so that a fine loop can take over. A count equal to the word, or one above it, counts as zero error, because edge counting over one reference period is only accurate to one edge.

Top module: `coarse_freq_loop`

## Requirements
- R1: The window enable (`osc_en`, and `dac_en` equal to it) is high for exactly one reference period. Consecutive windows open 10 reference periods apart.
- R2: Within a window, the block counts every rising edge of `osc_clk` into an 8-bit counter that starts from zero in each window and sticks at 255. A window with no oscillator edges yields a count of zero.
- R3: The evaluation takes place at the second rising `ref_clk` edge after the window closes. At that edge, the code becomes code + (fcw − count), except that the error is taken as zero when the count equals fcw or fcw + 1.
- R4: The tuning code saturates at 0 and 127. A count below the word never lowers the code, and a count above fcw + 1 never raises it.
- R5: At each evaluation, `coarse_zero` is set to 1 if the count is fcw or fcw + 1, and to 0 otherwise. It changes at no other edge.
- R6: `tune_code` is unchanged at every reference edge other than an evaluation edge, so it is held through the idle periods. The enables are low outside the window.
- R7: While `rst` is high (synchronous to `ref_clk`), the code equals `init_code`, the flag is 0 and the enables are 0. The first window opens at the ninth rising `ref_clk` edge after reset is released, and no evaluation takes place before the first window.
- R8: `fcw` is read at the evaluation edge. A change made during the idle period before that edge is used by that evaluation.
- R9: With an oscillator whose frequency rises linearly with the code and a reachable word, `coarse_zero` rises within 20 bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (ref domain) |
| osc_clk | input | 1 | Oscillator output whose edges are counted |
| fcw | input | 8 | Frequency word, expected edges per reference period |
| init_code | input | 7 | Code loaded by reset |
| tune_code | output | 7 | Coarse oscillator tuning code |
| osc_en | output | 1 | Oscillator enable, high during the window |
| dac_en | output | 1 | Tuning DAC enable, high during the window |
| coarse_zero | output | 1 | Coarse error is zero after the latest evaluation |

## Verification
In one evaluation cycle, the saturation clamp and the zero-error decision both act on the same count, and a word change can arrive in that same cycle. The bench provokes this by writing out-of-range words (5, then 70) right after a window closes. This drives the code onto each rail while the flag is forced low, and the scoreboard recomputes the clamped code and the flag from the word at the evaluation edge. A later return to a reachable word shows that the flag still rises after the code has left the rail.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  // signed coarse error, zero inside the one-edge quantization band
  function automatic int cfl_err(input int word, input int count);
    if (count == word || count == word + 1) return 0;
    return word - count;
  endfunction

  function automatic logic cfl_is_zero(input int word, input int count);
    return (count == word) || (count == word + 1);
  endfunction

  // accumulate with clamp to [0, max_code]
  function automatic int cfl_next(input int code, input int err, input int max_code);
    int s;
    s = code + err;
    if (s < 0) return 0;
    if (s > max_code) return max_code;
    return s;
  endfunction

endpackage

// File: rtl/cfl_sequencer.sv
module cfl_sequencer #(
  parameter int PERIOD = 10
) (
  input  logic ref_clk,
  input  logic rst,
  output logic win,
  output logic eval,
  output logic burst_tag
);
  localparam int PH_W   = $clog2(PERIOD);
  localparam int LAST   = PERIOD - 1;
  localparam int EVAL_P = 1;

  logic [PH_W-1:0] phase;
  logic            had_burst;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      phase     <= '0;
      had_burst <= 1'b0;
      burst_tag <= 1'b0;
    end else begin
      phase <= (phase == PH_W'(LAST)) ? '0 : phase + 1'b1;
      if (phase == PH_W'(LAST)) had_burst <= 1'b1;
      if (phase == PH_W'(LAST - 1)) burst_tag <= ~burst_tag;
    end
  end

  assign win  = !rst && (phase == PH_W'(LAST));
  assign eval = had_burst && (phase == PH_W'(EVAL_P));

  a_r1_single_period: assert property (@(posedge ref_clk) disable iff (rst)
    win |=> !win);
  a_r1_new_tag: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(win) |-> !$stable(burst_tag));
  a_r3_eval_timing: assert property (@(posedge ref_clk) disable iff (rst)
    eval |-> $past(win, 2));

endmodule

// File: rtl/cfl_edge_counter.sv
module cfl_edge_counter #(
  parameter int CNT_W = 8
) (
  input  logic             osc_clk,
  input  logic             rst,
  input  logic             win,
  input  logic             burst_tag,
  output logic [CNT_W-1:0] count,
  output logic             seen_tag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // oscillator is stopped during reset, so the clear cannot wait for an edge
  always_ff @(posedge osc_clk or posedge rst) begin
    if (rst) begin
      count    <= '0;
      seen_tag <= 1'b0;
    end else if (win) begin
      if (burst_tag != seen_tag) begin
        count    <= CNT_W'(1);
        seen_tag <= burst_tag;
      end else if (count != CNT_MAX) begin
        count <= count + 1'b1;
      end
    end
  end

  a_r2_no_wrap: assert property (@(posedge osc_clk) disable iff (rst)
    win && (burst_tag == seen_tag) |=> count >= $past(count));
  a_r2_idle_hold: assert property (@(posedge osc_clk) disable iff (rst)
    !win |=> $stable(count));

endmodule

// File: rtl/cfl_loop_update.sv
module cfl_loop_update
  import cfl_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              eval,
  input  logic [CNT_W-1:0]  fcw,
  input  logic [CNT_W-1:0]  count,
  input  logic              count_valid,
  input  logic [CODE_W-1:0] init_code,
  output logic [CODE_W-1:0] code,
  output logic              zero
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_eff;
  int               err_w;
  int               nxt_w;
  logic             zero_w;

  always_comb begin
    cnt_eff = count_valid ? count : '0;
    err_w   = cfl_err(int'(fcw), int'(cnt_eff));
    nxt_w   = cfl_next(int'(code), err_w, CODE_MAX);
    zero_w  = cfl_is_zero(int'(fcw), int'(cnt_eff));
  end

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      code <= init_code;
      zero <= 1'b0;
    end else if (eval) begin
      code <= CODE_W'(nxt_w);
      zero <= zero_w;
    end
  end

  a_r6_hold_code: assert property (@(posedge ref_clk) disable iff (rst)
    !eval |=> $stable(code));
  a_r5_hold_flag: assert property (@(posedge ref_clk) disable iff (rst)
    !eval |=> $stable(zero));
  a_r4_slow_up: assert property (@(posedge ref_clk) disable iff (rst)
    eval && (cnt_eff < fcw) |=> code >= $past(code));
  a_r4_fast_down: assert property (@(posedge ref_clk) disable iff (rst)
    eval && ({1'b0, cnt_eff} > {1'b0, fcw} + 1'b1) |=> code <= $past(code));

endmodule

// File: rtl/coarse_freq_loop.sv
module coarse_freq_loop #(
  parameter int PERIOD = 10,
  parameter int CODE_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              osc_clk,
  input  logic [CNT_W-1:0]  fcw,
  input  logic [CODE_W-1:0] init_code,
  output logic [CODE_W-1:0] tune_code,
  output logic              osc_en,
  output logic              dac_en,
  output logic              coarse_zero
);
  logic             win;
  logic             eval;
  logic             burst_tag;
  logic             seen_tag;
  logic [CNT_W-1:0] count;
  logic             count_valid;

  cfl_sequencer #(.PERIOD(PERIOD)) u_seq (
    .ref_clk  (ref_clk),
    .rst      (rst),
    .win      (win),
    .eval     (eval),
    .burst_tag(burst_tag)
  );

  cfl_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .osc_clk  (osc_clk),
    .rst      (rst),
    .win      (win),
    .burst_tag(burst_tag),
    .count    (count),
    .seen_tag (seen_tag)
  );

  // counter saw no edge in this burst when its tag still lags
  assign count_valid = (seen_tag == burst_tag);

  cfl_loop_update #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_upd (
    .ref_clk    (ref_clk),
    .rst        (rst),
    .eval       (eval),
    .fcw        (fcw),
    .count      (count),
    .count_valid(count_valid),
    .init_code  (init_code),
    .code       (tune_code),
    .zero       (coarse_zero)
  );

  assign osc_en = win;
  assign dac_en = win;

  a_r6_enables_idle: assert property (@(posedge ref_clk) disable iff (rst)
    !win |-> !osc_en && !dac_en);

endmodule

// File: tb/tb_coarse_freq_loop.sv
`timescale 1ps/1ps
module tb_coarse_freq_loop;
  localparam int REF_PERIOD = 50000;
  localparam int WATCHDOG   = 5000;

  logic       ref_clk = 0;
  logic       rst = 1;
  logic       osc_clk = 0;
  logic [7:0] fcw = 8'd30;
  logic [6:0] init_code = 7'd10;
  logic [6:0] tune_code;
  logic       osc_en, dac_en, coarse_zero;

  int checks = 0, fails = 0;
  int cnt_q[$];
  int m_code = 10;
  int burst_no = 0;
  int first_lock = -1;
  logic done = 0;

  coarse_freq_loop dut (
    .ref_clk(ref_clk), .rst(rst), .osc_clk(osc_clk), .fcw(fcw),
    .init_code(init_code), .tune_code(tune_code), .osc_en(osc_en),
    .dac_en(dac_en), .coarse_zero(coarse_zero));

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: oscillator model, edges only strictly inside the window
  always begin
    int n, per, half;
    longint t_end;
    wait (osc_en === 1'b1);
    t_end = $time + REF_PERIOD - 100;
    per = int'(1.0e6 / (200.0 + 8.0 * real'(tune_code)));
    half = per / 2;
    n = 0;
    while ($time + half < t_end) begin
      #(half);
      osc_clk = 1; n++;
      #(per - half);
      osc_clk = 0;
    end
    cnt_q.push_back(n);
    wait (osc_en === 1'b0);
  end

  // monitor: scoreboard for each evaluation
  always @(negedge osc_en) begin
    int n, e, f, exp_flag;
    if (!rst && !done) begin
      @(posedge ref_clk);
      @(negedge ref_clk);
      chk(tune_code == m_code, "R6 code held in idle", tune_code, m_code);
      chk(!osc_en && !dac_en, "R6 enables low in idle", {osc_en, dac_en}, 0);
      @(posedge ref_clk);
      @(negedge ref_clk);
      n = (cnt_q.size() > 0) ? cnt_q.pop_front() : -1;
      f = int'(fcw);
      e = (n == f || n == f + 1) ? 0 : f - n;
      m_code = m_code + e;
      if (m_code < 0) m_code = 0;
      if (m_code > 127) m_code = 127;
      exp_flag = (n == f || n == f + 1) ? 1 : 0;
      chk(tune_code == m_code, "R3/R4 code update", tune_code, m_code);
      chk(coarse_zero == exp_flag, "R5 zero flag", coarse_zero, exp_flag);
      burst_no++;
      if (exp_flag == 1 && first_lock < 0) first_lock = burst_no;
    end
  end

  // R1: window length and spacing
  int hi_len = 0, gap = 0;
  logic seen_rise = 0;
  always @(negedge ref_clk) begin
    if (!rst && !done) begin
      if (osc_en) begin
        hi_len++;
        if (hi_len == 1 && seen_rise) chk(gap == 10, "R1 window spacing", gap, 10);
        gap = 1;
        seen_rise = 1;
      end else begin
        if (hi_len != 0) chk(hi_len == 1, "R1 window length", hi_len, 1);
        hi_len = 0;
        gap++;
      end
    end
  end

  task automatic wait_bursts(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge osc_en);
      @(posedge ref_clk); @(posedge ref_clk); @(negedge ref_clk); #1;
    end
  endtask

  initial begin
    int edges;
    repeat (3) @(negedge ref_clk);
    chk(tune_code == 7'd10, "R7 reset code", tune_code, 10);
    chk(!osc_en && !dac_en, "R7 reset enables", {osc_en, dac_en}, 0);
    chk(coarse_zero == 0, "R7 reset flag", coarse_zero, 0);
    rst = 0;
    edges = 0;
    while (!osc_en) begin @(posedge ref_clk); edges++; #1; end
    chk(edges == 9, "R7 first window edge", edges, 9);
    chk(tune_code == 7'd10, "R7 no early evaluation", tune_code, 10);
    wait_bursts(24);
    chk(first_lock > 0 && first_lock <= 20, "R9 lock within 20 bursts", first_lock, 20);
    // R8 and R4 low rail: new word written in the idle slot before evaluation
    @(negedge osc_en); #1 fcw = 8'd5;
    @(posedge ref_clk); @(posedge ref_clk); @(negedge ref_clk);
    wait_bursts(10);
    chk(tune_code == 0, "R4 low rail", tune_code, 0);
    @(negedge osc_en); #1 fcw = 8'd70;
    @(posedge ref_clk); @(posedge ref_clk); @(negedge ref_clk);
    wait_bursts(10);
    chk(tune_code == 127, "R4 high rail", tune_code, 127);
    @(negedge osc_en); #1 fcw = 8'd15;
    @(posedge ref_clk); @(posedge ref_clk); @(negedge ref_clk);
    first_lock = -1; burst_no = 0;
    wait_bursts(20);
    chk(first_lock > 0, "R9 relock from high rail", first_lock, 1);
    chk(cnt_q.size() == 0, "R2 every burst measured", cnt_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge ref_clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule